// File: doc/BRIEF.md
# Register-Operand Execute Unit with Skip

This block is the execute step for the register-operand group of a 13-bit instruction word. When an instruction is presented, it places the 6-bit register address on a read port and receives the 8-bit operand from an external 64-entry register file. It then computes one of these operations:

- increment or decrement, with a skip when the result is zero;
- rotate through carry, left or right;
- nibble exchange;
- clear or set of one bit;
- test of one bit, with a skip.

One cycle later it presents the result, write strobes for the accumulator or the register file, the new carry, and a skip request for the next instruction.

The surrounding core owns the register file, the accumulator and the status register. It applies the strobes on the cycle they appear and drops the next instruction when `skip` is high. The carry flag comes in on `c_in`, and only the rotates return a new value for it.

Top module: `reg_alu_skip`

## Requirements
- R1: The register address is instruction bits 5..0 and appears on `rf_raddr` in the same cycle as the instruction. The bit index of the bit group is bits 8..6.
- R2: Bits 12..7 = 001011 is decrement. Bit 6 = 0 writes operand−1 to the accumulator, and bit 6 = 1 writes it back to the addressed register. `skip` is raised when the result is 0.
- R3: Bits 12..7 = 001111 is increment, with the same destination rule and a skip on a zero result.
- R4: Bits 12..7 = 001100 is rotate right. Bit n goes to n−1, old carry goes to bit 7 and bit 0 becomes the new carry. Bit 6 selects the destination as in R2.
- R5: Bits 12..7 = 001101 is rotate left. Bit n goes to n+1, old carry goes to bit 0 and bit 7 becomes the new carry. Bit 6 selects the destination.
- R6: Bits 12..7 = 001110 exchanges the two nibbles. Bit 6 selects the destination.
- R7: Bits 12..9 = 0100 clears the indexed bit and 0101 sets it. The result is always written back to the register.
- R8: Bits 12..9 = 0110 skips when the indexed bit is 0, and 0111 skips when it is 1. Neither writes anything.
- R9: `c_we` is high only for the rotates. No other operation changes the carry.
- R10: All outputs are registered and appear on the cycle after `instr_valid`. `skip` and the write strobes are one-cycle pulses in that same cycle. Without `instr_valid` everything stays low.
- R11: Any other encoding, including every word with bit 12 set, raises no strobe and no skip.
- R12: After reset all strobes and `skip` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 13 | Instruction word |
| c_in | input | 1 | Current carry flag |
| rf_raddr | output | 6 | Register file read address |
| rf_rdata | input | 8 | Operand from register file |
| acc_we | output | 1 | Write result to accumulator |
| rf_we | output | 1 | Write result to register file |
| rf_waddr | output | 6 | Register file write address |
| res_data | output | 8 | Result value |
| c_we | output | 1 | Carry update strobe |
| c_out | output | 1 | New carry value |
| skip | output | 1 | Skip the next instruction |

## Verification
A write-back and a skip can fall in the same cycle, and so can a carry update and a write. A decrement or increment that reaches zero raises `rf_we` or `acc_we` together with `skip`. A rotate raises `c_we` with a data write. The bench provokes these cases by preloading the operand with 1 or 0xFF before decrements and increments, and by running rotates with both carry values. A bench model computed from the requirement text judges every strobe, the data and the carry in the cycle after issue. The following cycle, with junk on `instr` and `instr_valid` low, must be quiet.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
  typedef enum logic [3:0] {
    OP_NONE,
    OP_DEC,
    OP_INC,
    OP_RRC,
    OP_RLC,
    OP_SWAP,
    OP_BCLR,
    OP_BSET,
    OP_TST0,
    OP_TST1
  } ralu_op_e;
endpackage

// File: rtl/ralu_decode.sv
module ralu_decode import ralu_pkg::*; #(
  parameter int INSTR_W = 13,
  parameter int ADDR_W  = 6,
  parameter int BIT_W   = 3
) (
  input  logic [INSTR_W-1:0] instr,
  output ralu_op_e           op,
  output logic               to_reg,
  output logic [ADDR_W-1:0]  addr,
  output logic [BIT_W-1:0]   bidx
);
  localparam int HI = INSTR_W - 1;

  assign addr = instr[ADDR_W-1:0];
  assign bidx = instr[ADDR_W +: BIT_W];

  always_comb begin
    op     = OP_NONE;
    to_reg = instr[ADDR_W];
    case (instr[HI -: 4])
      4'b0100: begin op = OP_BCLR; to_reg = 1'b1; end
      4'b0101: begin op = OP_BSET; to_reg = 1'b1; end
      4'b0110: op = OP_TST0;
      4'b0111: op = OP_TST1;
      default: begin
        case (instr[HI -: 6])
          6'b001011: op = OP_DEC;
          6'b001100: op = OP_RRC;
          6'b001101: op = OP_RLC;
          6'b001110: op = OP_SWAP;
          6'b001111: op = OP_INC;
          default:   op = OP_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ralu_bitsel.sv
module ralu_bitsel #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic [BIT_W-1:0]  bidx,
  output logic [DATA_W-1:0] mask
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_sel
    assign mask[g] = (bidx == BIT_W'(g));
  end
endmodule

// File: rtl/ralu_exec.sv
module ralu_exec import ralu_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  ralu_op_e          op,
  input  logic              to_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mask,
  input  logic              c_in,
  output logic              acc_we,
  output logic              rf_we,
  output logic              c_we,
  output logic              c_nxt,
  output logic              skip,
  output logic [DATA_W-1:0] res,
  output logic              ev_zero,
  output logic              ev_bit_hit,
  output logic              ev_rotate,
  output logic              ev_incdec
);
  localparam int HALF = DATA_W / 2;

  function automatic logic [DATA_W-1:0] f_step(input logic [DATA_W-1:0] v, input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  // returns {carry_out, data}
  function automatic logic [DATA_W:0] f_rot(input logic [DATA_W-1:0] v, input logic c,
                                            input logic left);
    return left ? {v, c} : {v[0], c, v[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] f_swap(input logic [DATA_W-1:0] v);
    return {v[HALF-1:0], v[DATA_W-1:HALF]};
  endfunction

  logic [DATA_W-1:0] step;
  logic [DATA_W:0]   rot;
  logic              wr;

  assign step       = f_step(operand, op == OP_INC);
  assign rot        = f_rot(operand, c_in, op == OP_RLC);
  assign ev_zero    = (step == '0);
  assign ev_bit_hit = |(operand & mask);
  assign ev_rotate  = (op == OP_RRC) || (op == OP_RLC);
  assign ev_incdec  = (op == OP_INC) || (op == OP_DEC);

  always_comb begin
    wr    = 1'b0;
    c_we  = 1'b0;
    c_nxt = 1'b0;
    skip  = 1'b0;
    res   = '0;
    case (op)
      OP_DEC, OP_INC: begin wr = 1'b1; res = step; skip = ev_zero; end
      OP_RRC, OP_RLC: begin
        wr = 1'b1; res = rot[DATA_W-1:0]; c_we = 1'b1; c_nxt = rot[DATA_W];
      end
      OP_SWAP: begin wr = 1'b1; res = f_swap(operand); end
      OP_BCLR: begin wr = 1'b1; res = operand & ~mask; end
      OP_BSET: begin wr = 1'b1; res = operand | mask; end
      OP_TST0: skip = !ev_bit_hit;
      OP_TST1: skip = ev_bit_hit;
      default: ;
    endcase
    acc_we = wr && !to_reg;
    rf_we  = wr && to_reg;
  end
endmodule

// File: rtl/ralu_outreg.sv
module ralu_outreg #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              acc_we_d,
  input  logic              rf_we_d,
  input  logic              c_we_d,
  input  logic              c_d,
  input  logic              skip_d,
  input  logic [DATA_W-1:0] data_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic              acc_we,
  output logic              rf_we,
  output logic              c_we,
  output logic              c_out,
  output logic              skip,
  output logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] waddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_we <= 1'b0;
      rf_we  <= 1'b0;
      c_we   <= 1'b0;
      c_out  <= 1'b0;
      skip   <= 1'b0;
      data   <= '0;
      waddr  <= '0;
    end else begin
      acc_we <= fire && acc_we_d;
      rf_we  <= fire && rf_we_d;
      c_we   <= fire && c_we_d;
      skip   <= fire && skip_d;
      if (fire) begin
        c_out <= c_d;
        data  <= data_d;
        waddr <= addr_d;
      end
    end
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_we && rf_we)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !(acc_we || rf_we || c_we || skip)); // R10
endmodule

// File: rtl/reg_alu_skip.sv
module reg_alu_skip import ralu_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int INSTR_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               c_in,
  output logic [ADDR_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               acc_we,
  output logic               rf_we,
  output logic [ADDR_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0]  res_data,
  output logic               c_we,
  output logic               c_out,
  output logic               skip
);
  localparam int BIT_W = $clog2(DATA_W);

  ralu_op_e          op;
  logic              to_reg;
  logic [BIT_W-1:0]  bidx;
  logic [DATA_W-1:0] mask;
  logic              x_acc_we, x_rf_we, x_c_we, x_c, x_skip;
  logic [DATA_W-1:0] x_res;
  logic              ev_zero, ev_bit_hit, ev_rotate, ev_incdec;

  ralu_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_dec (
    .instr (instr), .op(op), .to_reg(to_reg), .addr(rf_raddr), .bidx(bidx)
  );

  ralu_bitsel #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_sel (.bidx(bidx), .mask(mask));

  ralu_exec #(.DATA_W(DATA_W)) u_exec (
    .op(op), .to_reg(to_reg), .operand(rf_rdata), .mask(mask), .c_in(c_in),
    .acc_we(x_acc_we), .rf_we(x_rf_we), .c_we(x_c_we), .c_nxt(x_c), .skip(x_skip),
    .res(x_res), .ev_zero(ev_zero), .ev_bit_hit(ev_bit_hit), .ev_rotate(ev_rotate),
    .ev_incdec(ev_incdec)
  );

  ralu_outreg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(instr_valid),
    .acc_we_d(x_acc_we), .rf_we_d(x_rf_we), .c_we_d(x_c_we), .c_d(x_c),
    .skip_d(x_skip), .data_d(x_res), .addr_d(rf_raddr),
    .acc_we(acc_we), .rf_we(rf_we), .c_we(c_we), .c_out(c_out), .skip(skip),
    .data(res_data), .waddr(rf_waddr)
  );

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && op == OP_NONE |=> !(acc_we || rf_we || c_we || skip)); // R11
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && (op == OP_TST0 || op == OP_TST1) |=> !acc_we && !rf_we); // R8
  AST_CARRY_ROT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !ev_rotate |=> !c_we); // R9
  AST_STEP_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && ev_incdec |=> (skip == (res_data == '0))); // R3
  AST_BSET_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && op == OP_BSET |=> rf_we && ((res_data & $past(mask)) != '0)); // R7
endmodule

// File: tb/test_reg_alu_skip.sv
module test_reg_alu_skip;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [12:0] instr;
  logic        c_in;
  logic [5:0]  rf_raddr;
  logic [7:0]  rf_rdata;
  logic        acc_we, rf_we, c_we, c_out, skip;
  logic [5:0]  rf_waddr;
  logic [7:0]  res_data;

  logic [7:0]  mem [64];
  logic        c_flag;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 0;

  always #2 clk = ~clk;

  assign rf_rdata = mem[rf_raddr];
  assign c_in     = c_flag;

  reg_alu_skip i_reg_alu_skip (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .c_in(c_in),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .acc_we(acc_we), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .res_data(res_data), .c_we(c_we), .c_out(c_out), .skip(skip)
  );

  typedef struct packed {
    logic       a_we;
    logic       r_we;
    logic       cw;
    logic       cv;
    logic       sk;
    logic [7:0] d;
  } exp_t;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [12:0] ins);
    casez (ins[12:6])
      7'b001011?: return "R2";
      7'b001111?: return "R3";
      7'b001100?: return "R4";
      7'b001101?: return "R5";
      7'b001110?: return "R6";
      7'b010????: return "R7";
      7'b011????: return "R8";
      default:    return "R11";
    endcase
  endfunction

  function automatic exp_t model(input logic [12:0] ins, input logic [7:0] v, input logic c);
    exp_t e = '0;
    int   k = int'(ins[8:6]);
    casez (ins[12:6])
      7'b001011?: begin e.d = v - 8'd1; e.sk = (v == 8'd1); end
      7'b001111?: begin e.d = v + 8'd1; e.sk = (v == 8'hFF); end
      7'b001100?: begin e.d = {c, v[7:1]}; e.cw = 1; e.cv = v[0]; end
      7'b001101?: begin e.d = {v[6:0], c}; e.cw = 1; e.cv = v[7]; end
      7'b001110?: e.d = {v[3:0], v[7:4]};
      7'b0100???: begin e.d = v; e.d[k] = 1'b0; e.r_we = 1; end
      7'b0101???: begin e.d = v; e.d[k] = 1'b1; e.r_we = 1; end
      7'b0110???: e.sk = (v[k] == 1'b0);
      7'b0111???: e.sk = (v[k] == 1'b1);
      default: ;
    endcase
    if (ins[12:9] == 4'b0010 || ins[12:9] == 4'b0011) begin
      if (ins[12:7] != 6'b001010 && ins[12:7] != 6'b001000 && ins[12:7] != 6'b001001) begin
        if (ins[6]) e.r_we = 1; else e.a_we = 1;
      end
    end
    return e;
  endfunction

  task automatic run_op(input logic [12:0] ins);
    exp_t  e;
    string t;
    @(negedge clk);
    instr = ins; instr_valid = 1'b1;
    #1;
    check("R1", "rf_raddr", int'(rf_raddr), int'(ins[5:0]));
    e = model(ins, mem[ins[5:0]], c_flag);
    t = tag_of(ins);
    @(negedge clk);
    instr_valid = 1'b0; instr = 13'($urandom);
    check(t, "skip", int'(skip), int'(e.sk));
    check(t, "acc_we", int'(acc_we), int'(e.a_we));
    check(t, "rf_we", int'(rf_we), int'(e.r_we));
    check("R9", "c_we", int'(c_we), int'(e.cw));
    if (e.a_we || e.r_we) check(t, "res_data", int'(res_data), int'(e.d));
    if (e.r_we) check(t, "rf_waddr", int'(rf_waddr), int'(ins[5:0]));
    if (e.cw) check(t, "c_out", int'(c_out), int'(e.cv));
    if (rf_we) mem[rf_waddr] = res_data;
    if (c_we) c_flag = c_out;
    @(negedge clk);
    check("R10", "idle strobes", int'({acc_we, rf_we, c_we, skip}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] ins;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    c_flag = 1'b0; instr = '0; instr_valid = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", "reset strobes", int'({acc_we, rf_we, c_we, skip}), 0);
    rst_n = 1'b1;

    // directed corners
    mem[5] = 8'd1;   run_op({6'b001011, 1'b1, 6'd5});   // R2 to reg, hits zero
    mem[6] = 8'd1;   run_op({6'b001011, 1'b0, 6'd6});   // R2 to acc, hits zero
    mem[7] = 8'hFF;  run_op({6'b001111, 1'b1, 6'd7});   // R3 wraps to zero
    mem[8] = 8'h00;  run_op({6'b001111, 1'b0, 6'd8});   // R3 no skip
    c_flag = 1'b1; mem[9] = 8'h02; run_op({6'b001100, 1'b1, 6'd9}); // R4
    c_flag = 1'b1; mem[10] = 8'h80; run_op({6'b001101, 1'b0, 6'd10}); // R5
    mem[11] = 8'hA5; run_op({6'b001110, 1'b1, 6'd11}); // R6
    mem[12] = 8'hFF; run_op({4'b0100, 3'd7, 6'd12});   // R7 clear msb
    mem[13] = 8'h00; run_op({4'b0101, 3'd0, 6'd13});   // R7 set lsb
    mem[14] = 8'h80; run_op({4'b0111, 3'd7, 6'd14});   // R8 skip on one
    mem[15] = 8'hFE; run_op({4'b0110, 3'd0, 6'd15});   // R8 skip on zero
    run_op(13'h1805);                                  // R11 literal word
    run_op({6'b001010, 1'b1, 6'd3});                   // R11 neighbour code

    for (int n = 0; n < 800; n++) begin
      int          k    = int'($urandom % 11);
      logic [5:0]  a    = 6'($urandom);
      logic        rb   = 1'($urandom);
      logic [2:0]  b3   = 3'($urandom);
      case (k)
        0: begin ins = {6'b001011, rb, a}; if ($urandom % 3 == 0) mem[a] = 8'd1; end
        1: ins = {6'b001100, rb, a};
        2: ins = {6'b001101, rb, a};
        3: ins = {6'b001110, rb, a};
        4: begin ins = {6'b001111, rb, a}; if ($urandom % 3 == 0) mem[a] = 8'hFF; end
        5: ins = {4'b0100, b3, a};
        6: ins = {4'b0101, b3, a};
        7: ins = {4'b0110, b3, a};
        8: ins = {4'b0111, b3, a};
        9: ins = 13'($urandom);
        default: ins = {6'b001010, rb, a};
      endcase
      run_op(ins);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule